// File: doc/BRIEF.md
# Protocol Rule Violation Aggregator

This block takes the violation flags of a bank of bus-protocol rule monitors, one flag per rule and per bus clock, and reduces them to what a debug system needs: a single-cycle trigger to the trace capture unit, the number of the first rule that failed, a sticky record of every rule that has failed, and a saturating total of failures. Each rule has a suppress bit, so a rule with a known problem can be silenced without losing the others.

The suppress bits sit in a register loaded as one word through a write strobe and read back on `mask_o`. A clear command empties the sticky record, zeroes the count and re-arms the first-error latch. Once re-armed, the next unsuppressed violation latches a rule number and produces the trigger again. All outputs are registered. A violation sampled at one rising edge shows on the outputs from that edge onward.

Top module: `rule_violation_agg`

## Requirements
- R1: After reset the trigger is low, the valid flag is low, the rule number is 0, the sticky vector and the count are zero, and every suppress bit is 0, so all rules are active.
- R2: A rule whose suppress bit (`mask_o[k]` = 1 for rule k+1) is set at the sampling edge causes no trigger, no latch, no sticky bit and no count. A write of `mask_wdata_i` with `mask_we_i` high takes effect from the next edge onward.
- R3: `trig_o` is high for exactly one cycle, following the edge that samples the first unsuppressed violation while the unit is armed. Later violations do not raise it again until a clear.
- R4: The number of the first unsuppressed rule that fails is latched and held unchanged until a clear.
- R5: Bit k of `seen_o` is set once unsuppressed rule k+1 has failed, and it stays set until a clear.
- R6: At each edge the count grows by the number of unsuppressed rules that fail in that cycle.
- R7: The count saturates at its all-ones value and never wraps. It is 32 bits wide by default.
- R8: When several unsuppressed rules fail in the same cycle, the lowest-numbered one is latched.
- R9: Rule numbers are encoded 1 to 53 (flag bit k is rule k+1). A value of 0 with `first_valid_o` low means nothing is latched.
- R10: A clear takes priority over violations sampled in the same cycle. Those violations are dropped, and the suppress register is not affected by a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| viol_i | input | 53 | Per-rule violation flags, bit k is rule k+1 |
| mask_we_i | input | 1 | Load the suppress register |
| mask_wdata_i | input | 53 | New suppress bits |
| clear_i | input | 1 | Re-arm the latch, empty the sticky record, zero the count |
| mask_o | output | 53 | Current suppress bits |
| trig_o | output | 1 | One-cycle trigger to trace capture |
| first_valid_o | output | 1 | A first rule number is latched |
| first_rule_o | output | 6 | Latched rule number, 0 when none |
| seen_o | output | 53 | Sticky record of failed rules |
| count_o | output | 32 | Saturating violation count |

## Verification
Every piece of state in this block is driven straight to a port, so a wrong state shows on the very next edge. A suppress bit that is stored wrongly shows at once on `mask_o`. It also shows as a stray trigger, sticky bit or count step in the cycle after the suppressed rule fires. A latch that fails to hold, or a priority encoder that picks the wrong rule, shows on `first_rule_o` one edge after the multi-rule pattern that exposes it. A counter that wraps shows as a drop in `count_o` at the edge where it would overflow. The bench therefore builds the counter narrow, so that it reaches saturation quickly.

// File: rtl/rva_pkg.sv
package rva_pkg;
  localparam int unsigned DEF_RULES = 53;
  localparam int unsigned DEF_CNT_W = 32;

  function automatic int unsigned idx_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rva_mask_reg.sv
module rva_mask_reg #(
  parameter int unsigned N = 53
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/rva_prio_enc.sv
module rva_prio_enc #(
  parameter int unsigned N     = 53,
  parameter int unsigned IDX_W = 6
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // lowest set bit wins, encoded 1-based
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i + 1);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/rva_popcount.sv
module rva_popcount #(
  parameter int unsigned N = 53,
  parameter int unsigned W = 6
) (
  input  logic [N-1:0] in_i,
  output logic [W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + W'(in_i[i]);
  end
endmodule

// File: rtl/rva_sat_counter.sv
module rva_sat_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned INC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W:0] sum;
  assign sum = {1'b0, cnt_o} + (CNT_W + 1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= '0;
    else if (clr_i)       cnt_o <= '0;
    else if (sum[CNT_W])  cnt_o <= MAX;
    else                  cnt_o <= sum[CNT_W-1:0];
  end

  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_o == MAX) |=> cnt_o == MAX);

  p_monotonic_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_o >= $past(cnt_o));
endmodule

// File: rtl/rule_violation_agg.sv
module rule_violation_agg #(
  parameter int unsigned NUM_RULES = rva_pkg::DEF_RULES,
  parameter int unsigned CNT_W     = rva_pkg::DEF_CNT_W,
  localparam int unsigned IDX_W    = rva_pkg::idx_w(NUM_RULES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_RULES-1:0] viol_i,
  input  logic                 mask_we_i,
  input  logic [NUM_RULES-1:0] mask_wdata_i,
  input  logic                 clear_i,
  output logic [NUM_RULES-1:0] mask_o,
  output logic                 trig_o,
  output logic                 first_valid_o,
  output logic [IDX_W-1:0]     first_rule_o,
  output logic [NUM_RULES-1:0] seen_o,
  output logic [CNT_W-1:0]     count_o
);
  logic [NUM_RULES-1:0] live;
  logic [IDX_W-1:0]     low_idx;
  logic                 any_live;
  logic [IDX_W-1:0]     n_live;

  rva_mask_reg #(.N(NUM_RULES)) u_mask (
    .clk_i, .rst_ni, .we_i(mask_we_i), .wdata_i(mask_wdata_i), .mask_o(mask_o)
  );

  assign live = viol_i & ~mask_o;

  rva_prio_enc #(.N(NUM_RULES), .IDX_W(IDX_W)) u_prio (
    .req_i(live), .idx_o(low_idx), .any_o(any_live)
  );

  rva_popcount #(.N(NUM_RULES), .W(IDX_W)) u_pop (
    .in_i(live), .cnt_o(n_live)
  );

  rva_sat_counter #(.CNT_W(CNT_W), .INC_W(IDX_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(clear_i), .inc_i(n_live), .cnt_o(count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o        <= 1'b0;
      first_valid_o <= 1'b0;
      first_rule_o  <= '0;
      seen_o        <= '0;
    end else if (clear_i) begin
      trig_o        <= 1'b0;
      first_valid_o <= 1'b0;
      first_rule_o  <= '0;
      seen_o        <= '0;
    end else begin
      trig_o <= !first_valid_o && any_live;
      if (!first_valid_o && any_live) begin
        first_valid_o <= 1'b1;
        first_rule_o  <= low_idx;
      end
      seen_o <= seen_o | live;
    end
  end

  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  p_first_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_valid_o && !clear_i) |=> (first_valid_o && $stable(first_rule_o)));

  p_first_in_seen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_valid_o |-> seen_o[first_rule_o - 1'b1]);

  p_masked_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((viol_i & ~mask_o) == '0 && !clear_i) |=> (!trig_o && $stable(count_o) && $stable(seen_o)));

  p_clear_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!trig_o && !first_valid_o && seen_o == '0 && count_o == '0));

  p_code_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_valid_o |-> (first_rule_o >= 1 && first_rule_o <= IDX_W'(NUM_RULES)));
endmodule

// File: tb/rule_violation_agg_tb.sv
module rule_violation_agg_tb;
  localparam int N  = 53;
  localparam int CW = 8;
  localparam int IW = 6;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  viol = '0;
  logic          we = 1'b0;
  logic [N-1:0]  wd = '0;
  logic          clr = 1'b0;
  logic [N-1:0]  mask_o;
  logic          trig_o;
  logic          fv_o;
  logic [IW-1:0] fr_o;
  logic [N-1:0]  seen_o;
  logic [CW-1:0] cnt_o;

  rule_violation_agg #(.NUM_RULES(N), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .viol_i(viol), .mask_we_i(we),
    .mask_wdata_i(wd), .clear_i(clr), .mask_o(mask_o), .trig_o(trig_o),
    .first_valid_o(fv_o), .first_rule_o(fr_o), .seen_o(seen_o), .count_o(cnt_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vectors = 0;
  int errors  = 0;

  logic [N-1:0]  e_mask = '0;
  logic          e_trig = 1'b0;
  logic          e_fv = 1'b0;
  logic [IW-1:0] e_fr = '0;
  logic [N-1:0]  e_seen = '0;
  int            e_cnt = 0;
  logic [63:0]   rng = 64'h9E37_79B9_7F4A_7C15;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk("R3", {tag, " trig"}, longint'(trig_o), longint'(e_trig));
    chk("R9", {tag, " valid"}, longint'(fv_o), longint'(e_fv));
    chk("R4", {tag, " rule"}, longint'(fr_o), longint'(e_fr));
    chk("R5", {tag, " seen"}, longint'(seen_o), longint'(e_seen));
    chk("R6", {tag, " count"}, longint'(cnt_o), longint'(e_cnt));
    chk("R2", {tag, " mask"}, longint'(mask_o), longint'(e_mask));
  endtask

  // Apply one cycle of stimulus, update the model, check after the edge.
  task automatic step(input logic [N-1:0] v, input logic c, input logic w,
                      input logic [N-1:0] d, input string tag);
    logic [N-1:0] um;
    int low;
    @(negedge clk);
    viol = v; clr = c; we = w; wd = d;
    um = v & ~e_mask;
    if (c) begin
      e_trig = 1'b0; e_fv = 1'b0; e_fr = '0; e_seen = '0; e_cnt = 0;
    end else begin
      e_trig = !e_fv && (um != '0);
      if (e_trig) begin
        low = 0;
        for (int i = N - 1; i >= 0; i--) if (um[i]) low = i + 1;
        e_fv = 1'b1;
        e_fr = IW'(low);
      end
      e_seen = e_seen | um;
      e_cnt = e_cnt + $countones(um);
      if (e_cnt > (1 << CW) - 1) e_cnt = (1 << CW) - 1;
    end
    if (w) e_mask = d;
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : main
    logic [N-1:0] one;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R9 R4: walk each rule alone, clear in between
    for (int k = 0; k < N; k++) begin
      one = '0; one[k] = 1'b1;
      step(one, 1'b0, 1'b0, '0, "R9 walk");
      step('0, 1'b0, 1'b0, '0, "R3 idle after trig");
      step('0, 1'b1, 1'b0, '0, "R10 clear");
    end

    // R8: several rules in one cycle, lowest latched
    step({N{1'b1}}, 1'b0, 1'b0, '0, "R8 all fire");
    step('0, 1'b1, 1'b0, '0, "R10 clear");
    for (int k = 0; k < N - 1; k++) begin
      one = '0; one[N-1] = 1'b1; one[k] = 1'b1;
      step(one, 1'b0, 1'b0, '0, "R8 pair");
      step('0, 1'b1, 1'b0, '0, "R10 clear");
    end

    // R4 R3: later violations keep the latched rule and raise no trigger
    one = '0; one[40] = 1'b1;
    step(one, 1'b0, 1'b0, '0, "R4 first");
    one = '0; one[2] = 1'b1;
    step(one, 1'b0, 1'b0, '0, "R4 hold lower later");
    step(one, 1'b0, 1'b0, '0, "R3 no retrigger");

    // R10: clear together with violation drops it
    step({N{1'b1}}, 1'b1, 1'b0, '0, "R10 clear vs viol");
    step('0, 1'b0, 1'b0, '0, "R10 after clear");

    // R2: suppress each rule and fire it alone
    for (int k = 0; k < N; k++) begin
      one = '0; one[k] = 1'b1;
      step('0, 1'b0, 1'b1, one, "R2 load mask");
      step(one, 1'b0, 1'b0, '0, "R2 masked fire");
    end
    // R2: write lands at the edge, same-cycle violation uses old mask
    one = '0; one[10] = 1'b1;
    step(one, 1'b0, 1'b1, one, "R2 write timing");
    step(one, 1'b0, 1'b0, '0, "R2 now masked");
    step('0, 1'b1, 1'b1, '0, "R10 clear keeps mask write");

    // R6 R5: pseudo-random sparse traffic with random masks
    for (int n = 0; n < 600; n++) begin
      logic [N-1:0] a, b, m;
      rng = nxt(rng); a = rng[N-1:0];
      rng = nxt(rng); b = rng[N-1:0];
      rng = nxt(rng); m = rng[N-1:0];
      step(a & b & m, (rng[63:60] == 4'h0), (rng[59:57] == 3'b0), m & rng[40:0],
           "R6 random");
    end

    // R7: drive to saturation and beyond
    step('0, 1'b1, 1'b1, '0, "R7 prep");
    for (int n = 0; n < 8; n++) step({N{1'b1}}, 1'b0, 1'b0, '0, "R7 saturate");
    step({N{1'b1}}, 1'b0, 1'b0, '0, "R7 held at max");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule